// File: doc/BRIEF.md
# Latency-Aware Dispatch Router

This block is the dispatch stage of a two-wide out-of-order core. In each cycle it takes up to two decoded instructions in program order. It sends each one to exactly one of three queues: the main reorder buffer, an auxiliary buffer for short-latency results, or a region for instructions that write no register. Long-latency work (multiply, divide, memory access) always goes to the main reorder buffer. Short-latency work that writes a register goes to the auxiliary buffer. Everything else goes to the zero-register region.

Every dispatched instruction carries a group tag. A running counter advances by one for each long-latency or destination-less instruction dispatched, and that instruction takes the new value. A short-latency instruction takes the current value and leaves the counter unchanged. Each queue reports how many free entries it has as a saturating credit count. A slot that finds no room in its queue stalls, and every younger slot in that cycle stalls with it. A flush discards the cycle and reloads the counter with the group of the oldest instruction that survives.

Top module: `drt_dispatch_router`

## Requirements
- R1: An instruction of class multiply/divide (code 2'b01) or memory (code 2'b10) is sent to the main reorder buffer, whatever its destination flag.
- R2: An instruction of class ALU (2'b00) or control (2'b11) whose destination flag is low is sent to the zero-register region.
- R3: An instruction of class ALU or control whose destination flag is high is sent to the auxiliary buffer.
- R4: The group counter is 0 after reset. Each accepted reorder-buffer or zero-register instruction advances the counter by one and takes the new value. An accepted auxiliary instruction takes the current value. The sequence multiply, add, subtract, branch (no destination), store (no destination) yields the tags 1, 1, 1, 2, 3.
- R5: Within one cycle the slots are tagged in order, so slot 1 sees any advance caused by slot 0. Two advancing instructions in one cycle receive consecutive tags.
- R6: In one cycle a queue receives no more instructions than its credit input allows. Credits are taken by the slots in slot order.
- R7: A valid slot that is not accepted raises its stall bit, and so does every younger valid slot. An invalid slot neither stalls nor blocks a younger slot.
- R8: Enqueue strobes and tags are registered and appear one cycle after the inputs. At most one strobe per slot is set. A slot that is not enqueued shows tag 0. All outputs are 0 after reset.
- R9: While flush is high, no instruction is accepted and every valid slot stalls. The counter then loads the flush group value.
- R10: The counter is GW bits wide and wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NSLOT | Slot holds an instruction (bit 0 is oldest) |
| in_has_dst | input | NSLOT | Slot instruction writes a register |
| in_class | input | 2*NSLOT | Latency class per slot, slot i at bits [2i+1:2i] |
| rob_credit | input | CW | Free entries in the main reorder buffer (saturating) |
| aux_credit | input | CW | Free entries in the auxiliary buffer (saturating) |
| zrr_credit | input | CW | Free entries in the zero-register region (saturating) |
| flush | input | 1 | Discard this cycle and reload the group counter |
| flush_grp | input | GW | Group value loaded on flush |
| stall | output | NSLOT | Combinational: slot not accepted this cycle |
| enq_rob | output | NSLOT | Registered enqueue strobe to the main reorder buffer |
| enq_aux | output | NSLOT | Registered enqueue strobe to the auxiliary buffer |
| enq_zrr | output | NSLOT | Registered enqueue strobe to the zero-register region |
| out_grp | output | GW*NSLOT | Registered group tag, slot i at bits [GW*i+GW-1:GW*i] |

## Verification
The bench aims at two slots competing for the last credit of the same queue. A design that ignored credit order would overfill the queue or let slot 1 pass a stalled slot 0. It also covers two advancing instructions in one cycle, where a design that read the counter once for both slots would give them the same tag. It tests a store without a destination, which a design that checked the destination flag before the latency class would misroute into the zero-register region. Flush with valid inputs, and counter wrap from 63 to 0, catch a design that dispatches during a flush or saturates its counter.

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_MULDIV = 2'b01,
    CLS_MEM    = 2'b10,
    CLS_CTRL   = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROB  = 2'd1,
    TGT_AUX  = 2'd2,
    TGT_ZRR  = 2'd3
  } target_e;

  function automatic logic is_long(input logic [1:0] cls);
    return (cls == CLS_MULDIV) || (cls == CLS_MEM);
  endfunction
endpackage

// File: rtl/drt_classify.sv
module drt_classify
  import drt_pkg::*;
(
  input  logic       vld,
  input  logic       has_dst,
  input  logic [1:0] cls,
  output target_e    tgt
);
  always_comb begin
    if (!vld)               tgt = TGT_NONE;
    else if (is_long(cls))  tgt = TGT_ROB;
    else if (!has_dst)      tgt = TGT_ZRR;
    else                    tgt = TGT_AUX;
  end
endmodule

// File: rtl/drt_admit.sv
module drt_admit
  import drt_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int CW    = 2
) (
  input  target_e          tgt [NSLOT],
  input  logic [CW-1:0]    rob_credit,
  input  logic [CW-1:0]    aux_credit,
  input  logic [CW-1:0]    zrr_credit,
  input  logic             flush,
  output logic [NSLOT-1:0] acc,
  output logic [NSLOT-1:0] stall
);
  int  used_rob, used_aux, used_zrr;
  logic blocked, room;

  always_comb begin
    used_rob = 0;
    used_aux = 0;
    used_zrr = 0;
    blocked  = flush;
    room     = 1'b0;
    acc      = '0;
    stall    = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (tgt[i] != TGT_NONE) begin
        unique case (tgt[i])
          TGT_ROB: room = used_rob < int'(rob_credit);
          TGT_AUX: room = used_aux < int'(aux_credit);
          default: room = used_zrr < int'(zrr_credit);
        endcase
        if (!blocked && room) begin
          acc[i] = 1'b1;
          unique case (tgt[i])
            TGT_ROB: used_rob = used_rob + 1;
            TGT_AUX: used_aux = used_aux + 1;
            default: used_zrr = used_zrr + 1;
          endcase
        end else begin
          stall[i] = 1'b1;
          blocked  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/drt_group.sv
module drt_group
  import drt_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int GW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  target_e          tgt [NSLOT],
  input  logic [NSLOT-1:0] acc,
  input  logic             flush,
  input  logic [GW-1:0]    flush_grp,
  output logic [GW-1:0]    tag [NSLOT]
);
  logic [GW-1:0] cnt_q;
  logic [GW-1:0] run;

  always_comb begin
    run = cnt_q;
    for (int i = 0; i < NSLOT; i++) begin
      if (acc[i] && (tgt[i] == TGT_ROB || tgt[i] == TGT_ZRR))
        run = run + GW'(1);
      tag[i] = run;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (flush) cnt_q <= flush_grp;
    else            cnt_q <= run;
  end
endmodule

// File: rtl/drt_dispatch_router.sv
module drt_dispatch_router
  import drt_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int GW    = 6,
  parameter int CW    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSLOT-1:0]   in_valid,
  input  logic [NSLOT-1:0]   in_has_dst,
  input  logic [2*NSLOT-1:0] in_class,
  input  logic [CW-1:0]      rob_credit,
  input  logic [CW-1:0]      aux_credit,
  input  logic [CW-1:0]      zrr_credit,
  input  logic               flush,
  input  logic [GW-1:0]      flush_grp,
  output logic [NSLOT-1:0]   stall,
  output logic [NSLOT-1:0]   enq_rob,
  output logic [NSLOT-1:0]   enq_aux,
  output logic [NSLOT-1:0]   enq_zrr,
  output logic [GW*NSLOT-1:0] out_grp
);
  target_e          tgt [NSLOT];
  logic [NSLOT-1:0] acc;
  logic [GW-1:0]    tag [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_cls
    drt_classify u_cls (
      .vld     (in_valid[s]),
      .has_dst (in_has_dst[s]),
      .cls     (in_class[2*s +: 2]),
      .tgt     (tgt[s])
    );
  end

  drt_admit #(.NSLOT(NSLOT), .CW(CW)) u_admit (
    .tgt        (tgt),
    .rob_credit (rob_credit),
    .aux_credit (aux_credit),
    .zrr_credit (zrr_credit),
    .flush      (flush),
    .acc        (acc),
    .stall      (stall)
  );

  drt_group #(.NSLOT(NSLOT), .GW(GW)) u_grp (
    .clk       (clk),
    .rst       (rst),
    .tgt       (tgt),
    .acc       (acc),
    .flush     (flush),
    .flush_grp (flush_grp),
    .tag       (tag)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        enq_rob[s]          <= 1'b0;
        enq_aux[s]          <= 1'b0;
        enq_zrr[s]          <= 1'b0;
        out_grp[GW*s +: GW] <= '0;
      end else begin
        enq_rob[s]          <= acc[s] && tgt[s] == TGT_ROB;
        enq_aux[s]          <= acc[s] && tgt[s] == TGT_AUX;
        enq_zrr[s]          <= acc[s] && tgt[s] == TGT_ZRR;
        out_grp[GW*s +: GW] <= acc[s] ? tag[s] : '0;
      end
    end
  end
endmodule

// File: rtl/drt_dispatch_router_chk.sv
module drt_dispatch_router_chk #(
  parameter int NSLOT = 2,
  parameter int GW    = 6,
  parameter int CW    = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NSLOT-1:0]   in_valid,
  input logic [NSLOT-1:0]   in_has_dst,
  input logic [2*NSLOT-1:0] in_class,
  input logic [CW-1:0]      rob_credit,
  input logic [CW-1:0]      aux_credit,
  input logic [CW-1:0]      zrr_credit,
  input logic               flush,
  input logic [GW-1:0]      flush_grp,
  input logic [NSLOT-1:0]   stall,
  input logic [NSLOT-1:0]   enq_rob,
  input logic [NSLOT-1:0]   enq_aux,
  input logic [NSLOT-1:0]   enq_zrr,
  input logic [GW*NSLOT-1:0] out_grp
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_s
    a_r1_rob_long: assert property (@(posedge clk) disable iff (rst)
      enq_rob[s] |-> ($past(in_class[2*s +: 2]) == 2'b01 || $past(in_class[2*s +: 2]) == 2'b10));
    a_r2_zrr_nodst: assert property (@(posedge clk) disable iff (rst)
      enq_zrr[s] |-> (!$past(in_has_dst[s]) &&
                      ($past(in_class[2*s +: 2]) == 2'b00 || $past(in_class[2*s +: 2]) == 2'b11)));
    a_r3_aux_short: assert property (@(posedge clk) disable iff (rst)
      enq_aux[s] |-> ($past(in_has_dst[s]) &&
                      ($past(in_class[2*s +: 2]) == 2'b00 || $past(in_class[2*s +: 2]) == 2'b11)));
    a_r8_one_queue: assert property (@(posedge clk) disable iff (rst)
      $onehot0({enq_rob[s], enq_aux[s], enq_zrr[s]}));
    a_r7_stall_drops: assert property (@(posedge clk) disable iff (rst)
      stall[s] |=> !(enq_rob[s] || enq_aux[s] || enq_zrr[s]));
    if (s > 0) begin : g_young
      a_r7_younger_stalls: assert property (@(posedge clk) disable iff (rst)
        (stall[s-1] && in_valid[s]) |-> stall[s]);
    end
  end

  a_r6_rob_credit: assert property (@(posedge clk) disable iff (rst)
    $countones(enq_rob) <= int'($past(rob_credit)));
  a_r6_aux_credit: assert property (@(posedge clk) disable iff (rst)
    $countones(enq_aux) <= int'($past(aux_credit)));
  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    flush |=> (enq_rob == '0 && enq_aux == '0 && enq_zrr == '0));
  a_r5_pair_advance: assert property (@(posedge clk) disable iff (rst)
    ((enq_rob[0] || enq_aux[0] || enq_zrr[0]) && (enq_rob[1] || enq_zrr[1]))
      |-> out_grp[GW +: GW] == out_grp[0 +: GW] + GW'(1));
  a_r5_pair_hold: assert property (@(posedge clk) disable iff (rst)
    ((enq_rob[0] || enq_aux[0] || enq_zrr[0]) && enq_aux[1])
      |-> out_grp[GW +: GW] == out_grp[0 +: GW]);
endmodule

bind drt_dispatch_router drt_dispatch_router_chk #(.NSLOT(NSLOT), .GW(GW), .CW(CW)) u_chk (.*);

// File: tb/tb_drt_dispatch_router.sv
module tb_drt_dispatch_router;
  localparam int GW = 6;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] in_valid = '0, in_has_dst = '0;
  logic [3:0] in_class = '0;
  logic [CW-1:0] rob_credit = '0, aux_credit = '0, zrr_credit = '0;
  logic flush = 1'b0;
  logic [GW-1:0] flush_grp = '0;
  logic [1:0] stall, enq_rob, enq_aux, enq_zrr;
  logic [2*GW-1:0] out_grp;

  int checks = 0, errors = 0, mcnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  drt_dispatch_router #(.NSLOT(2), .GW(GW), .CW(CW)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 rob, 2 aux, 3 zrr
  task automatic cyc(input logic [1:0] v, input logic [1:0] d, input int c0, input int c1,
                     input int rc, input int ac, input int zc, input bit fl, input int fg);
    int cls[2];
    int kind[2];
    int used[4];
    int er[2], ea[2], ez[2], eg[2], es[2];
    bit blk;
    cls[0] = c0; cls[1] = c1;
    in_valid = v; in_has_dst = d;
    in_class = {2'(c1), 2'(c0)};
    rob_credit = CW'(rc); aux_credit = CW'(ac); zrr_credit = CW'(zc);
    flush = fl; flush_grp = GW'(fg);
    #1;
    used = '{0, 0, 0, 0};
    blk = fl;
    for (int s = 0; s < 2; s++) begin
      int cap;
      er[s] = 0; ea[s] = 0; ez[s] = 0; eg[s] = 0; es[s] = 0;
      if (!v[s]) kind[s] = 0;
      else if (cls[s] == 1 || cls[s] == 2) kind[s] = 1;
      else if (!d[s]) kind[s] = 3;
      else kind[s] = 2;
      if (kind[s] != 0) begin
        cap = (kind[s] == 1) ? rc : (kind[s] == 2) ? ac : zc;
        if (!blk && used[kind[s]] < cap) begin
          used[kind[s]]++;
          if (kind[s] != 2) mcnt = (mcnt + 1) % (1 << GW);
          eg[s] = mcnt;
          er[s] = (kind[s] == 1); ea[s] = (kind[s] == 2); ez[s] = (kind[s] == 3);
        end else begin
          es[s] = 1; blk = 1;
        end
      end
    end
    if (fl) mcnt = fg;
    for (int s = 0; s < 2; s++)
      chk(fl ? "R9" : "R7", $sformatf("stall[%0d]", s), int'(stall[s]), es[s]);
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      chk("R1", $sformatf("enq_rob[%0d]", s), int'(enq_rob[s]), er[s]);
      chk("R3", $sformatf("enq_aux[%0d]", s), int'(enq_aux[s]), ea[s]);
      chk("R2", $sformatf("enq_zrr[%0d]", s), int'(enq_zrr[s]), ez[s]);
      chk("R4", $sformatf("grp[%0d]", s), int'(out_grp[GW*s +: GW]), eg[s]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    chk("R8", "enq_rob", int'(enq_rob), 0);
    chk("R8", "enq_aux", int'(enq_aux), 0);
    chk("R8", "enq_zrr", int'(enq_zrr), 0);
    chk("R8", "out_grp", int'(out_grp), 0);

    // R4 example: MUL, ADD | SUB, BEQ | STORE
    cyc(2'b11, 2'b11, 1, 0, 3, 3, 3, 0, 0);
    chk("R4", "MUL tag", int'(out_grp[0 +: GW]), 1);
    chk("R4", "ADD tag", int'(out_grp[GW +: GW]), 1);
    cyc(2'b11, 2'b01, 0, 3, 3, 3, 3, 0, 0);
    chk("R4", "SUB tag", int'(out_grp[0 +: GW]), 1);
    chk("R4", "BEQ tag", int'(out_grp[GW +: GW]), 2);
    chk("R2", "BEQ zrr", int'(enq_zrr[1]), 1);
    cyc(2'b01, 2'b00, 2, 0, 3, 3, 3, 0, 0);
    chk("R4", "STORE tag", int'(out_grp[0 +: GW]), 3);
    chk("R1", "STORE rob", int'(enq_rob[0]), 1);

    // R5: two advancing instructions in one cycle
    cyc(2'b11, 2'b11, 1, 1, 3, 3, 3, 0, 0);
    chk("R5", "pair consecutive", int'(out_grp[GW +: GW]) - int'(out_grp[0 +: GW]), 1);
    // R3/R2: control with destination, ALU without
    cyc(2'b11, 2'b01, 3, 0, 3, 3, 3, 0, 0);
    // R6: one ROB credit, two ROB candidates
    cyc(2'b11, 2'b11, 1, 2, 1, 3, 3, 0, 0);
    chk("R6", "second rob stalled", int'(enq_rob), 1);
    // R7: slot 0 blocked, slot 1 would fit
    cyc(2'b11, 2'b11, 1, 0, 0, 3, 3, 0, 0);
    chk("R7", "no younger pass", int'(enq_aux), 0);
    // R7: invalid slot 0 does not block slot 1
    cyc(2'b10, 2'b10, 0, 0, 0, 1, 0, 0, 0);
    chk("R7", "bubble slot0", int'(enq_aux), 2);
    // R6: shared aux credit
    cyc(2'b11, 2'b11, 0, 3, 3, 1, 3, 0, 0);
    // R9 + R10: flush to 62 then wrap
    cyc(2'b11, 2'b11, 1, 1, 3, 3, 3, 1, 62);
    cyc(2'b11, 2'b00, 0, 2, 3, 3, 3, 0, 0);
    chk("R10", "wrap slot0", int'(out_grp[0 +: GW]), 63);
    chk("R10", "wrap slot1", int'(out_grp[GW +: GW]), 0);

    // random traffic against the model
    for (int n = 0; n < 400; n++)
      cyc(2'($urandom), 2'($urandom), int'($urandom % 4), int'($urandom % 4),
          int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
          ($urandom % 16) == 0, int'($urandom % 64));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule